// File: doc/BRIEF.md
# Accumulator with Link Bit

This block holds a working accumulator word and a one-bit link flag, and computes their next values from a set of one-hot operation selects. In each clock cycle at most one operation is requested: a bitwise AND or an addition with the data word, a load of the data word, a load of an input character into the low byte, a ones' complement, a rotate left or right through the link, an increment, or a clear. Two separate strobes clear or invert the link.

The addition puts its carry in the link. Both rotates pass through the link, so accumulator and link form a 17-bit ring. The block also reports whether the accumulator is zero and gives its sign bit, for use in skip decisions elsewhere in the datapath. Bus steering, instruction sequencing and memory sit outside the block.

Top module: `acc_link_unit`

## Requirements
- R1: While reset is asserted and after it is released with no operation requested, the accumulator is 0, the link is 0, the zero flag is 1 and the sign output is 0.
- R2: The AND select (sel_and) writes the bitwise AND of the accumulator and data_in into the accumulator and leaves the link unchanged.
- R3: The add select (sel_add) writes the low 16 bits of accumulator plus data_in into the accumulator and the carry out of bit 15 into the link.
- R4: The data load select (sel_load) copies data_in into the accumulator and leaves the link unchanged.
- R5: The character load select (sel_char) writes char_in into accumulator bits 7:0 and leaves bits 15:8 and the link unchanged.
- R6: The complement select (sel_cpl) inverts every accumulator bit and leaves the link unchanged.
- R7: The rotate right select (sel_ror) moves the link into accumulator bit 15, accumulator bits 15:1 into bits 14:0, and accumulator bit 0 into the link.
- R8: The rotate left select (sel_rol) moves the link into accumulator bit 0, accumulator bits 14:0 into bits 15:1, and accumulator bit 15 into the link.
- R9: The increment select (sel_inc) adds one to the accumulator, wrapping from 0xFFFF to 0x0000, and leaves the link unchanged.
- R10: The clear select (sel_clr) sets the accumulator to 0 and leaves the link unchanged.
- R11: With no select and no link strobe active, accumulator and link keep their values.
- R12: link_clr sets the link to 0 and link_cpl inverts it; when both are active the clear wins; when the add or a rotate select is active in the same cycle the link takes the value from that operation and both strobes are ignored. Strobes combined with any other select apply alongside it.
- R13: acc_zero is 1 exactly when the accumulator is 0, and acc_sign equals accumulator bit 15, in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_and | input | 1 | AND data_in into accumulator |
| sel_add | input | 1 | Add data_in, carry into link |
| sel_load | input | 1 | Load data_in into accumulator |
| sel_char | input | 1 | Load char_in into accumulator low byte |
| sel_cpl | input | 1 | Ones' complement of accumulator |
| sel_ror | input | 1 | Rotate right through link |
| sel_rol | input | 1 | Rotate left through link |
| sel_inc | input | 1 | Increment accumulator |
| sel_clr | input | 1 | Clear accumulator |
| link_clr | input | 1 | Clear link |
| link_cpl | input | 1 | Invert link |
| data_in | input | 16 | Data word operand |
| char_in | input | 8 | Input character |
| acc | output | 16 | Accumulator value |
| link | output | 1 | Link flag |
| acc_zero | output | 1 | Accumulator equals zero |
| acc_sign | output | 1 | Accumulator bit 15 |

## Verification
The properties rely on the nine operation selects being one-hot or all low in every cycle; one property states this rule as a check on the inputs, so a violation shows up as a failure rather than a silent priority pick. The random stimulus draws a single operation index per cycle, or none, and asserts only that select, so the rule always holds. The link strobes are drawn independently of the operation, which covers both the cases where an operation owns the link and those where the strobes decide it.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int unsigned NUM_SEL = 9;

  // Select vector bit positions (lowest index wins if several are raised)
  localparam int unsigned SEL_AND  = 0;
  localparam int unsigned SEL_ADD  = 1;
  localparam int unsigned SEL_LOAD = 2;
  localparam int unsigned SEL_CHAR = 3;
  localparam int unsigned SEL_CPL  = 4;
  localparam int unsigned SEL_ROR  = 5;
  localparam int unsigned SEL_ROL  = 6;
  localparam int unsigned SEL_INC  = 7;
  localparam int unsigned SEL_CLR  = 8;

  typedef enum logic [3:0] {
    ACC_HOLD = 4'd0,
    ACC_AND  = 4'd1,
    ACC_ADD  = 4'd2,
    ACC_LOAD = 4'd3,
    ACC_CHAR = 4'd4,
    ACC_CPL  = 4'd5,
    ACC_ROR  = 4'd6,
    ACC_ROL  = 4'd7,
    ACC_INC  = 4'd8,
    ACC_CLR  = 4'd9
  } acc_op_e;

endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/acc_op_encode.sv
module acc_op_encode
  import acc_pkg::*;
(
  input  logic [NUM_SEL-1:0] sel,
  output acc_op_e            op
);

  always_comb begin
    op = ACC_HOLD;
    for (int i = NUM_SEL - 1; i >= 0; i--) begin
      if (sel[i]) begin
        op = acc_op_e'(4'(i + 1));
      end
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  acc_op_e           op,
  input  logic [DATA_W-1:0] acc_q,
  input  logic              link_q,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              link_clr,
  input  logic              link_cpl,
  output logic [DATA_W-1:0] acc_d,
  output logic              acc_we,
  output logic              link_d,
  output logic              link_we
);

  localparam int unsigned HI_W = DATA_W - CHAR_W;

  logic [DATA_W:0]   sum_ext;
  logic [DATA_W-1:0] inc_val;
  logic              op_owns_link;
  logic              op_link_val;

  assign sum_ext = {1'b0, acc_q} + {1'b0, data_in};
  assign inc_val = acc_q + DATA_W'(1);

  // Accumulator network
  always_comb begin
    acc_d        = acc_q;
    acc_we       = 1'b1;
    op_owns_link = 1'b0;
    op_link_val  = link_q;
    unique case (op)
      ACC_AND:  acc_d = acc_q & data_in;
      ACC_ADD: begin
        acc_d        = sum_ext[DATA_W-1:0];
        op_owns_link = 1'b1;
        op_link_val  = sum_ext[DATA_W];
      end
      ACC_LOAD: acc_d = data_in;
      ACC_CHAR: acc_d = {acc_q[DATA_W-1 -: HI_W], char_in};
      ACC_CPL:  acc_d = ~acc_q;
      ACC_ROR: begin
        acc_d        = {link_q, acc_q[DATA_W-1:1]};
        op_owns_link = 1'b1;
        op_link_val  = acc_q[0];
      end
      ACC_ROL: begin
        acc_d        = {acc_q[DATA_W-2:0], link_q};
        op_owns_link = 1'b1;
        op_link_val  = acc_q[DATA_W-1];
      end
      ACC_INC:  acc_d = inc_val;
      ACC_CLR:  acc_d = '0;
      default:  acc_we = 1'b0;
    endcase
  end

  // Link network: an operation that produces a link value beats the strobes
  always_comb begin
    link_d  = link_q;
    link_we = 1'b0;
    if (op_owns_link) begin
      link_d  = op_link_val;
      link_we = 1'b1;
    end else if (link_clr) begin
      link_d  = 1'b0;
      link_we = 1'b1;
    end else if (link_cpl) begin
      link_d  = ~link_q;
      link_we = 1'b1;
    end
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_d,
  input  logic              link_we,
  input  logic              link_d,
  output logic [DATA_W-1:0] acc_q,
  output logic              link_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_we) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
    end else if (link_we) begin
      link_q <= link_d;
    end
  end

endmodule

// File: rtl/acc_link_unit.sv
module acc_link_unit
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_and,
  input  logic              sel_add,
  input  logic              sel_load,
  input  logic              sel_char,
  input  logic              sel_cpl,
  input  logic              sel_ror,
  input  logic              sel_rol,
  input  logic              sel_inc,
  input  logic              sel_clr,
  input  logic              link_clr,
  input  logic              link_cpl,
  input  logic [DATA_W-1:0] data_in,
  input  logic [CHAR_W-1:0] char_in,
  output logic [DATA_W-1:0] acc,
  output logic              link,
  output logic              acc_zero,
  output logic              acc_sign
);

  logic               rst_n_sync;
  logic [NUM_SEL-1:0] sel_vec;
  acc_op_e            op;
  logic [DATA_W-1:0]  acc_d;
  logic               acc_we;
  logic               link_d;
  logic               link_we;
  logic [DATA_W-1:0]  acc_q;
  logic               link_q;

  always_comb begin
    sel_vec           = '0;
    sel_vec[SEL_AND]  = sel_and;
    sel_vec[SEL_ADD]  = sel_add;
    sel_vec[SEL_LOAD] = sel_load;
    sel_vec[SEL_CHAR] = sel_char;
    sel_vec[SEL_CPL]  = sel_cpl;
    sel_vec[SEL_ROR]  = sel_ror;
    sel_vec[SEL_ROL]  = sel_rol;
    sel_vec[SEL_INC]  = sel_inc;
    sel_vec[SEL_CLR]  = sel_clr;
  end

  acc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  acc_op_encode u_encode (
    .sel (sel_vec),
    .op  (op)
  );

  acc_alu #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_alu (
    .op       (op),
    .acc_q    (acc_q),
    .link_q   (link_q),
    .data_in  (data_in),
    .char_in  (char_in),
    .link_clr (link_clr),
    .link_cpl (link_cpl),
    .acc_d    (acc_d),
    .acc_we   (acc_we),
    .link_d   (link_d),
    .link_we  (link_we)
  );

  acc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .acc_we  (acc_we),
    .acc_d   (acc_d),
    .link_we (link_we),
    .link_d  (link_d),
    .acc_q   (acc_q),
    .link_q  (link_q)
  );

  assign acc      = acc_q;
  assign link     = link_q;
  assign acc_zero = ~|acc_q;
  assign acc_sign = acc_q[DATA_W-1];

endmodule

// File: rtl/acc_link_chk.sv
module acc_link_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_and,
  input logic              sel_add,
  input logic              sel_load,
  input logic              sel_char,
  input logic              sel_cpl,
  input logic              sel_ror,
  input logic              sel_rol,
  input logic              sel_inc,
  input logic              sel_clr,
  input logic              link_clr,
  input logic              link_cpl,
  input logic [DATA_W-1:0] data_in,
  input logic [CHAR_W-1:0] char_in,
  input logic [DATA_W-1:0] acc,
  input logic              link
);

  logic [8:0] sels;
  logic       link_owner;
  assign sels = {sel_clr, sel_inc, sel_rol, sel_ror, sel_cpl,
                 sel_char, sel_load, sel_add, sel_and};
  assign link_owner = sel_add | sel_ror | sel_rol;

  // Input rule relied on by the R11 hold property and all operation checks
  assert_single_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sels) <= 1);

  assert_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_and |=> acc == ($past(acc) & $past(data_in)));

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_add |=> {link, acc} == ({1'b0, $past(acc)} + {1'b0, $past(data_in)}));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_load && !link_clr && !link_cpl) |=> (acc == $past(data_in)) && $stable(link));

  assert_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_char |=> (acc[CHAR_W-1:0] == $past(char_in))
                 && (acc[DATA_W-1:CHAR_W] == $past(acc[DATA_W-1:CHAR_W])));

  assert_cpl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cpl |=> acc == ~$past(acc));

  assert_ror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ror |=> (link == $past(acc[0])) && (acc[DATA_W-1] == $past(link)));

  assert_rol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rol |=> (link == $past(acc[DATA_W-1])) && (acc[0] == $past(link)));

  assert_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_inc && !link_clr && !link_cpl) |=> (acc == $past(acc) + DATA_W'(1)) && $stable(link));

  assert_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_clr |=> acc == '0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sels == '0 && !link_clr && !link_cpl) |=> $stable(acc) && $stable(link));

  assert_link_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_owner && link_clr) |=> !link);

  assert_link_invert_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_owner && !link_clr && link_cpl) |=> link != $past(link));

endmodule

bind acc_link_unit acc_link_chk #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .sel_and  (sel_and),
  .sel_add  (sel_add),
  .sel_load (sel_load),
  .sel_char (sel_char),
  .sel_cpl  (sel_cpl),
  .sel_ror  (sel_ror),
  .sel_rol  (sel_rol),
  .sel_inc  (sel_inc),
  .sel_clr  (sel_clr),
  .link_clr (link_clr),
  .link_cpl (link_cpl),
  .data_in  (data_in),
  .char_in  (char_in),
  .acc      (acc),
  .link     (link)
);

// File: tb/tb_acc_link_unit.sv
module tb_acc_link_unit;

  localparam int DW = 16;
  localparam int CW = 8;

  logic clk, rst_n;
  logic [8:0] sels;
  logic link_clr, link_cpl;
  logic [DW-1:0] data_in;
  logic [CW-1:0] char_in;
  logic [DW-1:0] acc;
  logic link, acc_zero, acc_sign;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [DW-1:0] m_acc;
  logic          m_link;

  acc_link_unit #(.DATA_W(DW), .CHAR_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .sel_and(sels[0]), .sel_add(sels[1]), .sel_load(sels[2]),
    .sel_char(sels[3]), .sel_cpl(sels[4]), .sel_ror(sels[5]),
    .sel_rol(sels[6]), .sel_inc(sels[7]), .sel_clr(sels[8]),
    .link_clr(link_clr), .link_cpl(link_cpl),
    .data_in(data_in), .char_in(char_in),
    .acc(acc), .link(link), .acc_zero(acc_zero), .acc_sign(acc_sign)
  );

  initial clk = 1'b0;
  always #4ns clk = ~clk;

  function automatic string tag_of(int k);
    case (k)
      0: return "R2";  1: return "R3";  2: return "R4";
      3: return "R5";  4: return "R6";  5: return "R7";
      6: return "R8";  7: return "R9";  8: return "R10";
      default: return "R11";
    endcase
  endfunction

  // Reference model step: k = 0..8 selects an operation, 9 = none
  function automatic logic [DW:0] model_next(int k, logic [DW-1:0] a, logic l,
                                             logic [DW-1:0] d, logic [CW-1:0] c,
                                             logic lc, logic lx);
    logic [DW-1:0] na = a;
    logic nl = l;
    logic owns = 1'b0;
    logic [DW:0] s;
    case (k)
      0: na = a & d;
      1: begin s = {1'b0, a} + {1'b0, d}; na = s[DW-1:0]; nl = s[DW]; owns = 1; end
      2: na = d;
      3: na = {a[DW-1:CW], c};
      4: na = ~a;
      5: begin na = {l, a[DW-1:1]}; nl = a[0]; owns = 1; end
      6: begin na = {a[DW-2:0], l}; nl = a[DW-1]; owns = 1; end
      7: na = a + 16'd1;
      8: na = '0;
      default: ;
    endcase
    if (!owns) begin
      if (lc) nl = 1'b0;
      else if (lx) nl = ~l;
    end
    return {nl, na};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_flags();
    chk("R13 zero", 32'(acc_zero), 32'(m_acc == '0));
    chk("R13 sign", 32'(acc_sign), 32'(m_acc[DW-1]));
  endtask

  // Called at a negedge: drive, let one rising edge pass, check at next negedge
  task automatic step(int k, logic [DW-1:0] d, logic [CW-1:0] c, logic lc, logic lx,
                      string ltag);
    logic [DW:0] nx;
    sels     = '0;
    if (k < 9) sels[k] = 1'b1;
    data_in  = d;
    char_in  = c;
    link_clr = lc;
    link_cpl = lx;
    nx = model_next(k, m_acc, m_link, d, c, lc, lx);
    @(negedge clk);
    sels = '0; link_clr = 0; link_cpl = 0;
    m_acc  = nx[DW-1:0];
    m_link = nx[DW];
    chk(tag_of(k), 32'(acc), 32'(m_acc));
    chk(ltag, 32'(link), 32'(m_link));
    check_flags();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    sels = '0; link_clr = 0; link_cpl = 0; data_in = '0; char_in = '0;
    rst_n = 1'b0;
    m_acc = '0; m_link = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 acc in reset", 32'(acc), 32'h0);
    chk("R1 link in reset", 32'(link), 32'h0);
    chk("R1 zero in reset", 32'(acc_zero), 32'h1);
    chk("R1 sign in reset", 32'(acc_sign), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 acc after release", 32'(acc), 32'h0);
    chk("R1 link after release", 32'(link), 32'h0);

    // Directed corners
    step(2, 16'hFFFF, 8'h00, 0, 0, "R4 link");          // load all ones
    step(1, 16'h0001, 8'h00, 0, 0, "R3 carry");         // FFFF+1 -> 0, link 1
    chk("R3 sum wraps", 32'(acc), 32'h0);
    chk("R3 carry set", 32'(link), 32'h1);
    step(2, 16'hFFFF, 8'h00, 0, 0, "R4 link");
    step(7, 16'h0000, 8'h00, 0, 0, "R9 link kept");     // wrap, link stays 1
    chk("R9 wrap to zero", 32'(acc), 32'h0);
    step(2, 16'hA5C3, 8'h00, 0, 0, "R4 link");
    step(3, 16'h0000, 8'h7E, 0, 0, "R5 link");          // high byte A5 kept
    chk("R5 high byte kept", 32'(acc), 32'hA57E);
    step(5, 16'h0000, 8'h00, 0, 0, "R7 link");
    step(6, 16'h0000, 8'h00, 0, 0, "R8 link");
    step(9, 16'h1234, 8'h55, 0, 0, "R11 link");         // idle with busy data
    step(9, 16'h0000, 8'h00, 1, 1, "R12 clear wins");
    chk("R12 clear beats invert", 32'(link), 32'h0);
    step(9, 16'h0000, 8'h00, 0, 1, "R12 invert");
    step(2, 16'h8000, 8'h00, 0, 0, "R4 link");
    step(1, 16'h8000, 8'h00, 1, 0, "R12 add beats clear");
    chk("R12 carry beats strobe", 32'(link), 32'h1);
    step(6, 16'h0000, 8'h00, 0, 1, "R12 rotate beats invert");
    step(8, 16'h0000, 8'h00, 0, 0, "R10 link");
    step(4, 16'h0000, 8'h00, 0, 0, "R6 link");

    // Constrained random: one operation or none per cycle
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      k = $urandom_range(0, 9);
      step(k, 16'($urandom), 8'($urandom), r[0] & r[1], r[2] & r[3],
           (k == 1 || k == 5 || k == 6) ? tag_of(k) : "R12 link");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule